// File: doc/BRIEF.md
# Multiply-accumulate unit with scaled readout

This block is a single-cycle signed multiply-accumulate engine with a 64-bit accumulator, kept as a low and a high 32-bit half. On each command strobe it multiplies two signed 32-bit operands into a full 64-bit product. It then either adds the product to the accumulator, subtracts it, or performs a read-and-clear. A read-and-clear returns a 32-bit window of the accumulator taken 28 bits up and zeroes the accumulator in the same cycle.

Software can also write and read each accumulator half directly through a special-register port. Every operation finishes in one clock, so the surrounding pipeline never has to stall or synchronise with the unit.

Top module: `mac_acc_unit`

## Requirements
- R1: A synchronous active-high reset clears both accumulator halves, drives `res_valid` low and `res_data` to zero, and drives `sr_rdata` to zero.
- R2: A command with `cmd_valid` high and `cmd_op` = 2'b00 adds the signed 64-bit product of `op_a` and `op_b` to the accumulator at that clock edge.
- R3: A command with `cmd_op` = 2'b01 subtracts the signed 64-bit product of `op_a` and `op_b` from the same accumulator at that clock edge.
- R4: A command with `cmd_op` = 2'b10 drives `res_data` with bits 59 to 28 of the accumulator value held before that edge. It also raises `res_valid`, and both take effect in the cycle after the command. `res_valid` is high for that one cycle only.
- R5: The read-and-clear command (2'b10) leaves both accumulator halves zero after the same edge that captures the result.
- R6: A command with `cmd_op` = 2'b11, or any cycle with `cmd_valid` low, leaves the accumulator unchanged and `res_valid` low.
- R7: With `sr_we` high, `sr_wdata` is written into the low half when `sr_sel` = 0 or into the high half when `sr_sel` = 1. The other half keeps its value.
- R8: `sr_rdata` shows the half chosen by `sr_sel` (0 low, 1 high) as it stood before the clock edge, registered at that edge.
- R9: A register write has priority: a command issued in the same cycle as `sr_we` is dropped. It neither changes the accumulator nor raises `res_valid`.
- R10: Accumulation wraps modulo 2^64 with no saturation. The high half holds bits 63 to 32 and the low half holds bits 31 to 0 of the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation: 00 add, 01 subtract, 10 read-and-clear, 11 none |
| op_a | input | 32 | Signed multiplicand |
| op_b | input | 32 | Signed multiplier |
| res_data | output | 32 | Scaled accumulator window from read-and-clear |
| res_valid | output | 1 | One-cycle pulse marking `res_data` |
| sr_we | input | 1 | Special-register write enable |
| sr_sel | input | 1 | Half select: 0 low, 1 high |
| sr_wdata | input | 32 | Special-register write data |
| sr_rdata | output | 32 | Registered value of the selected half |

## Verification
A wrong accumulator state stays inside the unit until something reads it out. It appears at `sr_rdata` one cycle after the affected half is selected, or at `res_data` one cycle after a read-and-clear. Errors in bits below 28 or above 59 show only through the register port. The bench therefore reads both halves after every accumulate and subtract step. Operand sweeps cover sign corners, so a wrong sign extension or a wrong carry into the high half shows within two cycles of the faulty step.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    MAC_ADD = 2'b00,
    MAC_SUB = 2'b01,
    MAC_RDC = 2'b10,
    MAC_NOP = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_product.sv
module mac_product #(
  parameter int OP_W = 32,
  localparam int PW = 2 * OP_W
) (
  input  logic [OP_W-1:0] a,
  input  logic [OP_W-1:0] b,
  output logic [PW-1:0]   p
);
  logic signed [PW-1:0] sa, sb;
  always_comb begin
    sa = PW'($signed(a));
    sb = PW'($signed(b));
    p  = sa * sb;
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int OP_W = 32,
  localparam int ACC_W = 2 * OP_W,
  localparam int HALVES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_add,
  input  logic             do_sub,
  input  logic             do_clr,
  input  logic             wr_en,
  input  logic             wr_hi,
  input  logic [OP_W-1:0]  wr_data,
  input  logic [ACC_W-1:0] prod,
  output logic [ACC_W-1:0] acc_q
);
  logic [ACC_W-1:0] acc_nx;

  always_comb begin
    if (do_clr)      acc_nx = '0;
    else if (do_add) acc_nx = acc_q + prod;
    else if (do_sub) acc_nx = acc_q - prod;
    else             acc_nx = acc_q;
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst)
        acc_q[h*OP_W +: OP_W] <= '0;
      else if (wr_en) begin
        if (wr_hi == 1'(h))
          acc_q[h*OP_W +: OP_W] <= wr_data;
      end else
        acc_q[h*OP_W +: OP_W] <= acc_nx[h*OP_W +: OP_W];
    end
  end
endmodule

// File: rtl/mac_readout.sv
module mac_readout #(
  parameter int OP_W  = 32,
  parameter int SHIFT = 28,
  localparam int ACC_W = 2 * OP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [ACC_W-1:0] acc,
  output logic [OP_W-1:0]  res_data,
  output logic             res_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_data  <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= fire;
      if (fire) res_data <= acc[SHIFT +: OP_W];
    end
  end
endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit #(
  parameter int OP_W  = 32,
  parameter int SHIFT = 28,
  localparam int ACC_W = 2 * OP_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [OP_W-1:0] op_a,
  input  logic [OP_W-1:0] op_b,
  output logic [OP_W-1:0] res_data,
  output logic            res_valid,
  input  logic            sr_we,
  input  logic            sr_sel,
  input  logic [OP_W-1:0] sr_wdata,
  output logic [OP_W-1:0] sr_rdata
);
  import mac_pkg::*;

  mac_op_e          op;
  logic             cmd_ok, do_add, do_sub, do_clr;
  logic [ACC_W-1:0] prod, acc_q;

  always_comb begin
    op     = mac_op_e'(cmd_op);
    cmd_ok = cmd_valid && !sr_we;
    do_add = cmd_ok && (op == MAC_ADD);
    do_sub = cmd_ok && (op == MAC_SUB);
    do_clr = cmd_ok && (op == MAC_RDC);
  end

  mac_product #(.OP_W(OP_W)) u_mul (.a(op_a), .b(op_b), .p(prod));

  mac_accum #(.OP_W(OP_W)) u_acc (
    .clk(clk), .rst(rst), .do_add(do_add), .do_sub(do_sub), .do_clr(do_clr),
    .wr_en(sr_we), .wr_hi(sr_sel), .wr_data(sr_wdata), .prod(prod), .acc_q(acc_q)
  );

  mac_readout #(.OP_W(OP_W), .SHIFT(SHIFT)) u_rd (
    .clk(clk), .rst(rst), .fire(do_clr), .acc(acc_q),
    .res_data(res_data), .res_valid(res_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) sr_rdata <= '0;
    else     sr_rdata <= sr_sel ? acc_q[OP_W +: OP_W] : acc_q[0 +: OP_W];
  end
endmodule

// File: rtl/mac_acc_chk.sv
module mac_acc_chk #(
  parameter int OP_W  = 32,
  parameter int SHIFT = 28,
  localparam int ACC_W = 2 * OP_W
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_valid,
  input logic [1:0]      cmd_op,
  input logic            sr_we,
  input logic            sr_sel,
  input logic [OP_W-1:0] sr_wdata,
  input logic [OP_W-1:0] sr_rdata,
  input logic [OP_W-1:0] res_data,
  input logic            res_valid,
  input logic [ACC_W-1:0] acc_q
);
  logic rdc_cmd, idle_cmd;
  assign rdc_cmd  = cmd_valid && !sr_we && cmd_op == 2'b10;
  assign idle_cmd = !sr_we && (!cmd_valid || cmd_op == 2'b11);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> acc_q == '0 && !res_valid);
  // R4
  rdc_window_chk: assert property (@(posedge clk) disable iff (rst)
    rdc_cmd |=> res_valid && res_data == $past(acc_q[SHIFT +: OP_W]));
  // R5
  rdc_zero_chk: assert property (@(posedge clk) disable iff (rst) rdc_cmd |=> acc_q == '0);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    idle_cmd |=> $stable(acc_q) && !res_valid);
  // R7
  wr_other_half_chk: assert property (@(posedge clk) disable iff (rst)
    (sr_we && !sr_sel) |=> acc_q[OP_W +: OP_W] == $past(acc_q[OP_W +: OP_W])
                          && acc_q[0 +: OP_W] == $past(sr_wdata));
  // R9
  wr_drops_cmd_chk: assert property (@(posedge clk) disable iff (rst) sr_we |=> !res_valid);
  // R8
  rd_path_chk: assert property (@(posedge clk) disable iff (rst)
    !sr_sel |=> sr_rdata == $past(acc_q[0 +: OP_W]));
endmodule

bind mac_acc_unit mac_acc_chk #(.OP_W(OP_W), .SHIFT(SHIFT)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .sr_we(sr_we),
  .sr_sel(sr_sel), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .res_data(res_data),
  .res_valid(res_valid), .acc_q(acc_q)
);

// File: tb/sim_mac_acc_unit.sv
module sim_mac_acc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, sr_we = 1'b0, sr_sel = 1'b0, res_valid;
  logic [1:0] cmd_op = 2'b00;
  logic [W-1:0] op_a = '0, op_b = '0, sr_wdata = '0, res_data, sr_rdata;

  int total = 0, bad = 0;
  bit done = 0;
  logic [63:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_acc_unit u0 (.clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .op_a(op_a), .op_b(op_b), .res_data(res_data), .res_valid(res_valid),
    .sr_we(sr_we), .sr_sel(sr_sel), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op; op_a = a; op_b = b;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic check_acc(string tag);
    @(negedge clk); sr_sel = 1'b0;
    @(negedge clk); chk({tag, " lo"}, 64'(sr_rdata), 64'(model[31:0]));
    sr_sel = 1'b1;
    @(negedge clk); chk({tag, " hi"}, 64'(sr_rdata), 64'(model[63:32]));
  endtask

  task automatic wr(logic sel, logic [W-1:0] d);
    @(negedge clk); sr_we = 1'b1; sr_sel = sel; sr_wdata = d;
    @(negedge clk); sr_we = 1'b0;
  endtask

  function automatic logic [63:0] prd(logic [W-1:0] a, logic [W-1:0] b);
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    return 64'(sa * sb);
  endfunction

  logic [W-1:0] vals [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                             32'h8000_0000, 32'd12345, 32'hFFFF_FCF7, 32'h1000_0000};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 res_valid", 64'(res_valid), 64'd0);
    chk("R1 res_data", 64'(res_data), 64'd0);
    chk("R1 sr_rdata", 64'(sr_rdata), 64'd0);
    check_acc("R1 acc");

    // R2 / R10 sweep: accumulate over all operand pairs, wrapping
    foreach (vals[i]) foreach (vals[j]) begin
      cmd(2'b00, vals[i], vals[j]);
      model = model + prd(vals[i], vals[j]);
      check_acc("R2/R10 add");
    end
    // R3 sweep: subtract over all pairs
    foreach (vals[i]) foreach (vals[j]) begin
      cmd(2'b01, vals[j], vals[i]);
      model = model - prd(vals[j], vals[i]);
      check_acc("R3 sub");
    end

    // R4 / R5 readout of several loaded values
    for (int k = 0; k < 6; k++) begin
      logic [63:0] v;
      v = {vals[k], vals[7-k]} ^ 64'h0123_4567_89AB_CDEF;
      wr(1'b0, v[31:0]);
      wr(1'b1, v[63:32]);
      model = v;
      check_acc("R7 write");
      @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'b10;
      @(negedge clk); cmd_valid = 1'b0;
      chk("R4 res_valid", 64'(res_valid), 64'd1);
      chk("R4 res_data", 64'(res_data), 64'(v[59:28]));
      @(negedge clk);
      chk("R4 pulse", 64'(res_valid), 64'd0);
      model = '0;
      check_acc("R5 cleared");
    end

    // R6: reserved opcode and strobe low
    wr(1'b0, 32'hDEAD_BEEF); wr(1'b1, 32'h0000_0042);
    model = 64'h0000_0042_DEAD_BEEF;
    cmd(2'b11, 32'h5, 32'h7);
    chk("R6 no pulse", 64'(res_valid), 64'd0);
    @(negedge clk); cmd_op = 2'b00; op_a = 32'h9; op_b = 32'h9;
    repeat (3) @(negedge clk);
    check_acc("R6 unchanged");

    // R9: write with readout in same cycle
    @(negedge clk); sr_we = 1'b1; sr_sel = 1'b1; sr_wdata = 32'h1234_5678;
    cmd_valid = 1'b1; cmd_op = 2'b10;
    @(negedge clk); sr_we = 1'b0; cmd_valid = 1'b0;
    chk("R9 no pulse", 64'(res_valid), 64'd0);
    model[63:32] = 32'h1234_5678;
    check_acc("R9 acc");
    // R9: write with add in same cycle
    @(negedge clk); sr_we = 1'b1; sr_sel = 1'b0; sr_wdata = 32'h0000_0001;
    cmd_valid = 1'b1; cmd_op = 2'b00; op_a = 32'h100; op_b = 32'h100;
    @(negedge clk); sr_we = 1'b0; cmd_valid = 1'b0;
    model[31:0] = 32'h1;
    check_acc("R9 add dropped");

    // R1 again: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model = '0;
    check_acc("R1 rerun");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule